// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This block sits at the front of a processor's exception delivery path. Each time a fault is raised, it decides whether that fault can be delivered as it is, or whether it must be promoted because of a fault that is still being delivered. The block remembers one tracked fault. It sorts every vector into one of four classes: contributory (vectors 0 and 10 to 13), page fault (vector 14), double fault (vector 8), or other.

A contributory fault that arrives over a pending contributory fault becomes a double fault. So does a contributory fault or a page fault that arrives over a pending page fault. Any non-software fault that arrives while a double fault is pending is a triple fault. In guest mode a triple fault raises a guest-exit request. Outside guest mode it raises a shutdown request, and the output vector becomes the halt code. Software interrupts bypass the check. The result is registered and appears one cycle after the raise strobe. The clear strobe marks the end of a successful delivery and empties the tracker.

Top module: `exc_escalate`

## Requirements
- R1: After reset, valid_o, shutdown_o, guest_exit_o, vec_o and err_o are all 0. The tracker is empty, so a first vector 0 is delivered unchanged.
- R2: valid_o is high in exactly the cycle after a cycle with raise_i high. vec_o and err_o change only after a raise and hold their values otherwise.
- R3: A non-software contributory vector (0, 10, 11, 12, 13) raised while a contributory vector is tracked produces vec_o = 8 and err_o = 0.
- R4: A non-software contributory vector or vector 14 raised while vector 14 is tracked produces vec_o = 8 and err_o = 0.
- R5: Vector 14 raised while a contributory vector is tracked is delivered unchanged, with its error code kept.
- R6: Any other class pairing without a tracked vector 8 is delivered unchanged. This covers a vector outside the three classes, a new vector with an empty tracker, and vector 8 raised directly.
- R7: A non-software raise while vector 8 is tracked, with guest_i low, asserts shutdown_o and produces vec_o = 256 (bit VEC_W set, the halt code). err_o passes through and guest_exit_o stays low.
- R8: The same raise with guest_i high asserts guest_exit_o, passes the vector and error code through, and keeps shutdown_o low.
- R9: A raise with soft_i high passes vector and error code through, never asserts shutdown_o or guest_exit_o, and leaves the tracker unchanged.
- R10: clear_i empties the tracker. When raise_i and clear_i are high in the same cycle, the raise takes effect and the clear is ignored.
- R11: The tracker loads the resulting vector only when that vector is contributory, 14 or 8. A triple fault leaves the tracker at 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raise_i | input | 1 | Raise strobe for a new exception |
| vec_i | input | VEC_W | Raised vector number |
| soft_i | input | 1 | Raise comes from a software interrupt instruction |
| guest_i | input | 1 | Processor is running a guest |
| err_i | input | ERR_W | Incoming error code |
| clear_i | input | 1 | Delivery done; empty the tracker |
| valid_o | output | 1 | Result valid (one cycle after raise) |
| vec_o | output | VEC_W+1 | Final vector; 1 in bit VEC_W is the halt code |
| err_o | output | ERR_W | Adjusted error code |
| shutdown_o | output | 1 | System reset request on triple fault |
| guest_exit_o | output | 1 | Guest shutdown exit on triple fault |

## Verification
The hardest state to reach is a tracked double fault. From the ports, it takes either a direct raise of vector 8 from an empty tracker, or an escalating raise over a contributory or page-fault vector. Each test sequence therefore clears the tracker, raises a setup vector, raises the vector under test with every combination of soft_i and guest_i, and then raises a probe vector 0. The probe's outcome shows what the tracker held, so the rule for when the tracker loads is checked at the ports. A raise and a clear issued in the same cycle are driven on purpose to show that the raise wins.

// File: rtl/exc_escalate_pkg.sv
package exc_escalate_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER   = 2'd0,
    CLS_CONTRIB = 2'd1,
    CLS_PAGE    = 2'd2,
    CLS_DOUBLE  = 2'd3
  } exc_cls_e;

  localparam int unsigned VEC_DIVIDE     = 0;
  localparam int unsigned VEC_DOUBLE     = 8;
  localparam int unsigned VEC_CONTRIB_LO = 10;
  localparam int unsigned VEC_CONTRIB_HI = 13;
  localparam int unsigned VEC_PAGE       = 14;
endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_escalate_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic [VEC_W-1:0] vec_i,
  output exc_cls_e         cls_o
);
  always_comb begin
    if (vec_i == VEC_W'(VEC_DOUBLE))
      cls_o = CLS_DOUBLE;
    else if (vec_i == VEC_W'(VEC_PAGE))
      cls_o = CLS_PAGE;
    else if (vec_i == VEC_W'(VEC_DIVIDE) ||
             (vec_i >= VEC_W'(VEC_CONTRIB_LO) && vec_i <= VEC_W'(VEC_CONTRIB_HI)))
      cls_o = CLS_CONTRIB;
    else
      cls_o = CLS_OTHER;
  end
endmodule

// File: rtl/exc_escalate_rule.sv
module exc_escalate_rule
  import exc_escalate_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned ERR_W = 32,
  localparam int unsigned OUT_W = VEC_W + 1
) (
  input  logic             trk_valid_i,
  input  exc_cls_e         trk_cls_i,
  input  exc_cls_e         new_cls_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             soft_i,
  input  logic             guest_i,
  output logic [OUT_W-1:0] res_vec_o,
  output logic [ERR_W-1:0] res_err_o,
  output logic             shutdown_o,
  output logic             guest_exit_o,
  output logic             trk_load_o,
  output logic [VEC_W-1:0] trk_next_o
);
  localparam logic [OUT_W-1:0] HALT_CODE = {1'b1, {VEC_W{1'b0}}};

  logic new_contrib, new_page, escalate;

  assign new_contrib = (new_cls_i == CLS_CONTRIB);
  assign new_page    = (new_cls_i == CLS_PAGE);
  assign escalate    = trk_valid_i &&
                       ((trk_cls_i == CLS_CONTRIB && new_contrib) ||
                        (trk_cls_i == CLS_PAGE && (new_contrib || new_page)));

  always_comb begin
    res_vec_o    = {1'b0, vec_i};
    res_err_o    = err_i;
    shutdown_o   = 1'b0;
    guest_exit_o = 1'b0;
    trk_load_o   = 1'b0;
    trk_next_o   = vec_i;
    if (!soft_i) begin
      if (trk_valid_i && trk_cls_i == CLS_DOUBLE) begin
        // triple fault: tracker stays at double fault
        if (guest_i) begin
          guest_exit_o = 1'b1;
        end else begin
          shutdown_o = 1'b1;
          res_vec_o  = HALT_CODE;
        end
      end else if (escalate) begin
        res_vec_o  = OUT_W'(VEC_DOUBLE);
        res_err_o  = '0;
        trk_next_o = VEC_W'(VEC_DOUBLE);
        trk_load_o = 1'b1;
      end else begin
        trk_load_o = (new_cls_i != CLS_OTHER);
      end
    end
  end
endmodule

// File: rtl/exc_track_reg.sv
module exc_track_reg #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      vec_o   <= vec_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_escalate_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned ERR_W = 32,
  localparam int unsigned OUT_W = VEC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             soft_i,
  input  logic             guest_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             clear_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] vec_o,
  output logic [ERR_W-1:0] err_o,
  output logic             shutdown_o,
  output logic             guest_exit_o
);
  logic             trk_valid;
  logic [VEC_W-1:0] trk_vec;
  logic [VEC_W-1:0] dec_vec [2];
  exc_cls_e         dec_cls [2];

  logic [OUT_W-1:0] res_vec;
  logic [ERR_W-1:0] res_err;
  logic             res_sd, res_ge, res_load;
  logic [VEC_W-1:0] trk_next;

  assign dec_vec[0] = vec_i;
  assign dec_vec[1] = trk_vec;

  // index 0: incoming vector, index 1: tracked vector
  for (genvar g = 0; g < 2; g++) begin : g_dec
    exc_class_decode #(.VEC_W(VEC_W)) i_dec (
      .vec_i (dec_vec[g]),
      .cls_o (dec_cls[g])
    );
  end

  exc_escalate_rule #(.VEC_W(VEC_W), .ERR_W(ERR_W)) i_rule (
    .trk_valid_i  (trk_valid),
    .trk_cls_i    (dec_cls[1]),
    .new_cls_i    (dec_cls[0]),
    .vec_i        (vec_i),
    .err_i        (err_i),
    .soft_i       (soft_i),
    .guest_i      (guest_i),
    .res_vec_o    (res_vec),
    .res_err_o    (res_err),
    .shutdown_o   (res_sd),
    .guest_exit_o (res_ge),
    .trk_load_o   (res_load),
    .trk_next_o   (trk_next)
  );

  exc_track_reg #(.VEC_W(VEC_W)) i_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (raise_i & res_load),
    .clear_i (clear_i & ~raise_i),
    .vec_i   (trk_next),
    .valid_o (trk_valid),
    .vec_o   (trk_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      shutdown_o   <= 1'b0;
      guest_exit_o <= 1'b0;
      vec_o        <= '0;
      err_o        <= '0;
    end else begin
      valid_o      <= raise_i;
      shutdown_o   <= raise_i & res_sd;
      guest_exit_o <= raise_i & res_ge;
      if (raise_i) begin
        vec_o <= res_vec;
        err_o <= res_err;
      end
    end
  end
endmodule

// File: rtl/exc_escalate_chk.sv
module exc_escalate_chk #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned ERR_W = 32,
  localparam int unsigned OUT_W = VEC_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             raise_i,
  input logic [VEC_W-1:0] vec_i,
  input logic             soft_i,
  input logic             clear_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] vec_o,
  input logic [ERR_W-1:0] err_o,
  input logic             shutdown_o,
  input logic             guest_exit_o,
  input logic             trk_valid,
  input logic [VEC_W-1:0] trk_vec
);
  function automatic logic is_contrib(input logic [VEC_W-1:0] v);
    return (v == '0) || (v >= VEC_W'(10) && v <= VEC_W'(13));
  endfunction

  p_valid_after_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> valid_o);

  p_no_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raise_i |=> (!valid_o && $stable(vec_o) && $stable(err_o)));

  p_contrib_pair_df_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_i && !soft_i && trk_valid && is_contrib(trk_vec) && is_contrib(vec_i))
      |=> (vec_o == OUT_W'(8) && err_o == '0));

  p_exit_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shutdown_o, guest_exit_o}));

  p_halt_on_shutdown_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (valid_o && vec_o[VEC_W]));

  p_guest_exit_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guest_exit_o |-> (valid_o && !vec_o[VEC_W]));

  p_soft_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_i && soft_i) |=> (vec_o == {1'b0, $past(vec_i)} && !shutdown_o &&
                             !guest_exit_o && $stable(trk_valid) && $stable(trk_vec)));

  p_clear_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !raise_i) |=> !trk_valid);
endmodule

bind exc_escalate exc_escalate_chk #(.VEC_W(VEC_W), .ERR_W(ERR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .raise_i      (raise_i),
  .vec_i        (vec_i),
  .soft_i       (soft_i),
  .clear_i      (clear_i),
  .valid_o      (valid_o),
  .vec_o        (vec_o),
  .err_o        (err_o),
  .shutdown_o   (shutdown_o),
  .guest_exit_o (guest_exit_o),
  .trk_valid    (trk_valid),
  .trk_vec      (trk_vec)
);

// File: tb/test_exc_escalate.sv
`timescale 1ns/1ps
module test_exc_escalate;
  localparam int VEC_W = 8;
  localparam int ERR_W = 32;
  localparam int HALT  = 256;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic raise_i = 1'b0, soft_i = 1'b0, guest_i = 1'b0, clear_i = 1'b0;
  logic [VEC_W-1:0] vec_i = '0;
  logic [ERR_W-1:0] err_i = '0;
  logic valid_o, shutdown_o, guest_exit_o;
  logic [VEC_W:0] vec_o;
  logic [ERR_W-1:0] err_o;

  int checks = 0, fails = 0;
  bit m_tv = 0;
  int m_tr = 0;

  always #10 clk_i = ~clk_i;

  exc_escalate #(.VEC_W(VEC_W), .ERR_W(ERR_W)) i_exc_escalate (
    .clk_i, .rst_ni, .raise_i, .vec_i, .soft_i, .guest_i, .err_i, .clear_i,
    .valid_o, .vec_o, .err_o, .shutdown_o, .guest_exit_o
  );

  function automatic bit contrib(int v);
    return v == 0 || (v >= 10 && v <= 13);
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_raise(int v, logic [31:0] e, bit s, bit g, bit c, string tag_in);
    int ev; logic [31:0] ee; bit esd, ege; string tag;
    bit esc;
    ev = v; ee = e; esd = 0; ege = 0; tag = "R6";
    if (s) tag = "R9";
    else if (m_tv && m_tr == 8) begin
      if (g) begin ege = 1; tag = "R8"; end
      else begin esd = 1; ev = HALT; tag = "R7"; end
    end else begin
      esc = m_tv && ((contrib(m_tr) && contrib(v)) || (m_tr == 14 && (contrib(v) || v == 14)));
      if (esc) begin
        ev = 8; ee = 0;
        tag = (m_tr == 14) ? "R4" : "R3";
      end else if (m_tv && contrib(m_tr) && v == 14) tag = "R5";
      if (contrib(ev) || ev == 14 || ev == 8) begin m_tv = 1; m_tr = ev; end
    end
    if (tag_in != "") tag = tag_in;
    @(negedge clk_i);
    raise_i = 1; vec_i = v[VEC_W-1:0]; err_i = e; soft_i = s; guest_i = g; clear_i = c;
    @(negedge clk_i);
    raise_i = 0; clear_i = 0; soft_i = 0; guest_i = 0;
    check(tag, {20'd0, valid_o, shutdown_o, guest_exit_o, vec_o, err_o},
               {20'd0, 1'b1, esd, ege, 9'(ev), ee});
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1;
    @(negedge clk_i);
    clear_i = 0;
    m_tv = 0;
    check("R10", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int setv[10] = '{0, 3, 8, 10, 11, 12, 13, 14, 15, 255};
    logic [VEC_W:0] held;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", {20'd0, valid_o, shutdown_o, guest_exit_o, vec_o, err_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    do_raise(0, 32'h1234, 0, 0, 0, "R1");   // first divide error, no escalation
    // R2: idle holds outputs
    held = vec_o;
    repeat (2) @(negedge clk_i);
    check("R2", {54'd0, valid_o, vec_o}, {54'd0, 1'b0, held});

    // pending x new x soft x guest, then probe vector 0 to expose tracker (R11)
    for (int p = -1; p < 10; p++) begin
      for (int n = 0; n < 10; n++) begin
        for (int sg = 0; sg < 4; sg++) begin
          do_clear();
          if (p >= 0) do_raise(setv[p], 32'hA500_0000 | p, 0, 0, 0, "");
          do_raise(setv[n], {8'(n), 8'(p), 16'hC35A}, sg[0], sg[1], 0, "");
          do_raise(0, 32'h0000_7777, 0, 0, 0, "R11");
        end
      end
    end

    // R10: raise and clear together, raise wins
    do_clear();
    do_raise(0, 32'h55, 0, 0, 0, "R10");
    do_raise(10, 32'h66, 0, 0, 1, "R10");   // escalates to 8, clear ignored
    do_raise(0, 32'h77, 0, 0, 0, "R10");    // triple fault proves tracker kept 8
    do_clear();
    do_raise(12, 32'h88, 0, 0, 0, "R10");   // empty after clear: passes

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule